// File: doc/BRIEF.md
# SDRAM Refresh Scheduler with Self-Refresh Control

This block keeps an SDRAM array alive. A programmable interval timer raises a refresh request at a fixed cadence; once the access path reports that it is idle, the block drives a single auto-refresh command onto the SDRAM command pins. It then raises a busy flag that locks out normal accesses until the row cycle time has passed. If the access path stays busy long enough for further intervals to expire, a saturating counter records each refresh that could not be issued in time.

The same block also handles self-refresh. A sleep request, or selecting self-refresh as the refresh mode, makes the block issue the refresh command with clock enable driven low in the same cycle. It then keeps clock enable low and the command pins deselected for as long as self-refresh is wanted. When self-refresh is released, clock enable returns high and accesses stay locked out for one more row cycle time. Normal read and write sequencing and power-up initialisation belong to other blocks.

Top module: `sdram_refresh_ctl`

## Requirements
- R1: After reset, refreshReq and busy are 0, cke is 1, cmdPins is 4'b1111 (deselect) and missedCount is 0.
- R2: With refresh enabled, auto mode and accessIdle held high, successive refresh commands are exactly 2049 - refCount clock cycles apart.
- R3: cmdPins is ordered {cs_n, ras_n, cas_n, we_n}. A refresh command is 4'b0001 and lasts exactly one cycle. In every other cycle the pins are 4'b1111.
- R4: After an auto refresh, busy is high for exactly Trc cycles, counting the command cycle. Trc = (4 + semiRowCode) + (2 + prechargeCode).
- R5: prechargeCode 2'b11 is treated as 4 clocks, the same as code 2'b10.
- R6: While accessIdle is low, no refresh command is issued and refreshReq stays high. The command appears in the first cycle after accessIdle returns high.
- R7: Each interval expiry that finds a refresh still pending adds one to missedCount. The count saturates at 255.
- R8: While refEnable is 0, no refresh command is issued and refreshReq stays 0.
- R9: When sleepReq rises while the block is idle, the next cycle carries the refresh command with cke low. After that, cke stays low, busy stays high and the pins stay deselected for as long as sleepReq is held.
- R10: When self-refresh is released, cke is high in the next cycle. busy then stays high for exactly Trc cycles, counting that cycle.
- R11: With selfMode set to 1 and refresh enabled, the block enters self-refresh exactly as in R9 and issues no auto refresh. Clearing refEnable releases it as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refEnable | input | 1 | Master enable for all refresh activity |
| selfMode | input | 1 | 0 selects auto refresh, 1 selects self-refresh |
| refCount | input | 11 | Interval value; period is 2049 - refCount clocks |
| prechargeCode | input | 2 | Precharge time: 2, 3 or 4 clocks (code 3 treated as 4) |
| semiRowCode | input | 2 | Semi row cycle time: 4 to 7 clocks |
| accessIdle | input | 1 | Access path has no transaction in flight |
| sleepReq | input | 1 | Request to place the SDRAM in self-refresh |
| refreshReq | output | 1 | A refresh is pending |
| busy | output | 1 | Normal accesses must be held off |
| cmdPins | output | 4 | {cs_n, ras_n, cas_n, we_n} command pins |
| cke | output | 1 | SDRAM clock enable |
| missedCount | output | 8 | Saturating count of late refreshes |

## Verification
The assertions take three things for granted. The timing fields stay stable while a refresh window is running. accessIdle is an honest report from the access path. A refresh command is only checked against the idle and enable levels of the cycle that launched it. The stimulus changes fields and the enable only between scenarios, under reset, and changes accessIdle, sleepReq and selfMode only on the falling edge. Intervals are chosen longer than the row cycle, so that a lock-out never overlaps an expiry unless a scenario sets out to test that.

// File: rtl/ref_pkg.sv
package ref_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOCK, ST_SELF, ST_EXIT} refState_t;

  typedef struct packed {
    logic issueRef;
    logic enterSelf;
    logic exitSelf;
  } refStrobes_t;

  localparam logic [3:0] PINS_REFRESH  = 4'b0001;
  localparam logic [3:0] PINS_DESELECT = 4'b1111;
endpackage

// File: rtl/ref_datapath.sv
module ref_datapath import ref_pkg::*; #(
  parameter int CNT_W  = 11,
  parameter int MISS_W = 8,
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refEnable,
  input  logic              selfMode,
  input  logic [CNT_W-1:0]  refCount,
  input  logic [1:0]        prechargeCode,
  input  logic [1:0]        semiRowCode,
  input  logic              inSelf,
  input  refStrobes_t       strobes,
  output logic              pending,
  output logic              lockDone,
  output logic [MISS_W-1:0] missedCount,
  output logic [3:0]        cmdPins,
  output logic              cke
);
  localparam int PER_W = CNT_W + 1;
  localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

  logic [PER_W-1:0]  intervalCnt;
  logic [PER_W-1:0]  periodM1;
  logic [LOCK_W-1:0] lockCnt;
  logic [LOCK_W-1:0] trcM1;
  logic [1:0]        preEff;
  logic              run;
  logic              tick;
  logic              refIssued;

  // period minus one = 2^CNT_W - refCount
  assign periodM1  = (PER_W'(1) << CNT_W) - {1'b0, refCount};
  assign preEff    = (prechargeCode == 2'b11) ? 2'd2 : prechargeCode;
  // Trc - 1 = (4 + semi) + (2 + pre) - 1
  assign trcM1     = LOCK_W'(5) + LOCK_W'(semiRowCode) + LOCK_W'(preEff);
  assign run       = refEnable && !selfMode && !inSelf;
  assign tick      = run && (intervalCnt == '0);
  assign refIssued = strobes.issueRef || strobes.enterSelf;
  assign lockDone  = (lockCnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intervalCnt <= '0;
      pending     <= 1'b0;
      missedCount <= '0;
      lockCnt     <= '0;
      cmdPins     <= PINS_DESELECT;
      cke         <= 1'b1;
    end else begin
      if (!run || intervalCnt == '0) intervalCnt <= periodM1;
      else                           intervalCnt <= intervalCnt - 1'b1;

      if (!refEnable)     pending <= 1'b0;
      else if (tick)      pending <= 1'b1;
      else if (refIssued) pending <= 1'b0;

      if (tick && pending && !refIssued && missedCount != MISS_MAX)
        missedCount <= missedCount + 1'b1;

      if (strobes.issueRef || strobes.exitSelf) lockCnt <= trcM1;
      else if (!lockDone)                       lockCnt <= lockCnt - 1'b1;

      cmdPins <= refIssued ? PINS_REFRESH : PINS_DESELECT;

      if (strobes.enterSelf)     cke <= 1'b0;
      else if (strobes.exitSelf) cke <= 1'b1;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (missedCount == MISS_MAX) |=> (missedCount == MISS_MAX));

  // R8
  ref_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdPins == PINS_REFRESH) |-> $past(refEnable));

  // R3
  ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdPins == PINS_REFRESH) |=> (cmdPins == PINS_DESELECT));
endmodule

// File: rtl/ref_control.sv
module ref_control import ref_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        refEnable,
  input  logic        selfMode,
  input  logic        sleepReq,
  input  logic        accessIdle,
  input  logic        pending,
  input  logic        lockDone,
  output refStrobes_t strobes,
  output logic        busy,
  output logic        inSelf
);
  refState_t state, stateNext;
  logic      selfWanted;

  assign selfWanted = refEnable && (selfMode || sleepReq);

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (selfWanted && accessIdle) begin
          strobes.enterSelf = 1'b1;
          stateNext         = ST_SELF;
        end else if (refEnable && pending && accessIdle) begin
          strobes.issueRef = 1'b1;
          stateNext        = ST_LOCK;
        end
      end
      ST_LOCK: if (lockDone) stateNext = ST_IDLE;
      ST_SELF: begin
        if (!selfWanted) begin
          strobes.exitSelf = 1'b1;
          stateNext        = ST_EXIT;
        end
      end
      ST_EXIT: if (lockDone) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign busy   = (state != ST_IDLE);
  assign inSelf = (state == ST_SELF);

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  // R4
  issue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.issueRef |=> busy);

  // R10
  exit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.exitSelf |=> (busy && !inSelf));
endmodule

// File: rtl/sdram_refresh_ctl.sv
module sdram_refresh_ctl import ref_pkg::*; #(
  parameter int CNT_W  = 11,
  parameter int MISS_W = 8,
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refEnable,
  input  logic              selfMode,
  input  logic [CNT_W-1:0]  refCount,
  input  logic [1:0]        prechargeCode,
  input  logic [1:0]        semiRowCode,
  input  logic              accessIdle,
  input  logic              sleepReq,
  output logic              refreshReq,
  output logic              busy,
  output logic [3:0]        cmdPins,
  output logic              cke,
  output logic [MISS_W-1:0] missedCount
);
  refStrobes_t strobes;
  logic        pending;
  logic        lockDone;
  logic        inSelf;

  ref_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .refEnable(refEnable), .selfMode(selfMode),
    .sleepReq(sleepReq), .accessIdle(accessIdle), .pending(pending),
    .lockDone(lockDone), .strobes(strobes), .busy(busy), .inSelf(inSelf)
  );

  ref_datapath #(.CNT_W(CNT_W), .MISS_W(MISS_W), .LOCK_W(LOCK_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .refEnable(refEnable), .selfMode(selfMode),
    .refCount(refCount), .prechargeCode(prechargeCode),
    .semiRowCode(semiRowCode), .inSelf(inSelf), .strobes(strobes),
    .pending(pending), .lockDone(lockDone), .missedCount(missedCount),
    .cmdPins(cmdPins), .cke(cke)
  );

  assign refreshReq = pending;

  // R6
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdPins == PINS_REFRESH) |-> $past(accessIdle));

  // R9
  cke_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> busy);
endmodule

// File: tb/sdram_refresh_ctl_test.sv
`timescale 1ns/1ps
module sdram_refresh_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        refEnable, selfMode, accessIdle, sleepReq;
  logic [10:0] refCount;
  logic [1:0]  prechargeCode, semiRowCode;
  logic        refreshReq, busy, cke;
  logic [3:0]  cmdPins;
  logic [7:0]  missedCount;

  int checks = 0;
  int errors = 0;

  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] NOP = 4'b1111;

  always #4 clk = ~clk;

  sdram_refresh_ctl uut (
    .clk(clk), .rst_n(rst_n), .refEnable(refEnable), .selfMode(selfMode),
    .refCount(refCount), .prechargeCode(prechargeCode), .semiRowCode(semiRowCode),
    .accessIdle(accessIdle), .sleepReq(sleepReq), .refreshReq(refreshReq),
    .busy(busy), .cmdPins(cmdPins), .cke(cke), .missedCount(missedCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic en, input logic sm, input logic [10:0] cnt,
                         input logic [1:0] pre, input logic [1:0] semi);
    @(negedge clk);
    rst_n = 1'b0; refEnable = en; selfMode = sm; refCount = cnt;
    prechargeCode = pre; semiRowCode = semi; accessIdle = 1'b1; sleepReq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // waits on negedges until a refresh command is seen; returns cycles waited
  task automatic waitRef(output int cyc);
    cyc = 0;
    while (cmdPins != REF && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    doReset(1'b0, 1'b0, 11'd0, 2'd0, 2'd0);
    @(negedge clk);
    check(refreshReq == 0 && busy == 0, "R1 req/busy", {refreshReq, busy}, 0);
    check(cke == 1, "R1 cke", cke, 1);
    check(cmdPins == NOP, "R1 pins", cmdPins, NOP);
    check(missedCount == 0, "R1 missed", missedCount, 0);
  endtask

  task automatic testPeriod();
    int w, gap, n;
    doReset(1'b1, 1'b0, 11'd2040, 2'd0, 2'd0);
    waitRef(w);
    @(negedge clk);
    check(cmdPins == NOP, "R3 single cycle", cmdPins, NOP);
    gap = 1;
    waitRef(w);
    gap += w;
    check(gap == 9, "R2 period", gap, 9);
    busyLen(n);
    check(n == 6, "R4 trc 4+2", n, 6);
  endtask

  task automatic testTrc(input logic [1:0] pre, input logic [1:0] semi,
                         input int exp, input string req);
    int w, n;
    doReset(1'b1, 1'b0, 11'd2030, pre, semi);
    waitRef(w);
    check(cmdPins == REF, {req, " cmd"}, cmdPins, REF);
    busyLen(n);
    check(n == exp, req, n, exp);
  endtask

  task automatic testHold();
    int refs = 0;
    int w = 0;
    doReset(1'b1, 1'b0, 11'd2040, 2'd1, 2'd1);
    accessIdle = 1'b0;
    while (!refreshReq && w < 100) begin
      @(negedge clk);
      w++;
      if (cmdPins == REF) refs++;
    end
    for (int i = 0; i < 27; i++) begin
      @(negedge clk);
      if (cmdPins == REF) refs++;
    end
    check(refs == 0, "R6 no refresh while busy path", refs, 0);
    check(refreshReq == 1, "R6 request held", refreshReq, 1);
    check(missedCount == 3, "R7 missed count", missedCount, 3);
    accessIdle = 1'b1;
    @(negedge clk);
    check(cmdPins == REF, "R6 issue after idle", cmdPins, REF);
    check(refreshReq == 0, "R6 request cleared", refreshReq, 0);
  endtask

  task automatic testSaturate();
    doReset(1'b1, 1'b0, 11'd2047, 2'd0, 2'd0);
    accessIdle = 1'b0;
    repeat (600) @(negedge clk);
    check(missedCount == 255, "R7 saturation", missedCount, 255);
  endtask

  task automatic testDisable();
    int refs = 0;
    doReset(1'b0, 1'b0, 11'd2047, 2'd0, 2'd0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (cmdPins == REF) refs++;
    end
    check(refs == 0, "R8 no refresh when disabled", refs, 0);
    check(refreshReq == 0, "R8 no request", refreshReq, 0);
  endtask

  task automatic testSleep();
    int bad = 0;
    int n;
    doReset(1'b1, 1'b0, 11'd2030, 2'd1, 2'd1);
    sleepReq = 1'b1;
    @(negedge clk);
    check(cmdPins == REF && cke == 0, "R9 entry cmd with cke low", {cmdPins, cke}, {REF, 1'b0});
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (cke || !busy || cmdPins != NOP) bad++;
    end
    check(bad == 0, "R9 held in self refresh", bad, 0);
    sleepReq = 1'b0;
    @(negedge clk);
    check(cke == 1, "R10 cke raised", cke, 1);
    busyLen(n);
    check(n == 8, "R10 exit lockout", n, 8);
  endtask

  task automatic testSelfMode();
    int bad = 0;
    int n;
    doReset(1'b1, 1'b1, 11'd2047, 2'd0, 2'd2);
    @(negedge clk);
    check(cmdPins == REF && cke == 0, "R11 self mode entry", {cmdPins, cke}, {REF, 1'b0});
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cke || cmdPins != NOP) bad++;
    end
    check(bad == 0, "R11 no auto refresh in self mode", bad, 0);
    refEnable = 1'b0;
    @(negedge clk);
    check(cke == 1, "R11 release by disable", cke, 1);
    busyLen(n);
    check(n == 8, "R11 exit lockout", n, 8);
  endtask

  initial begin
    testReset();
    testPeriod();
    testTrc(2'd2, 2'd3, 11, "R4 trc 7+4");
    testTrc(2'd3, 2'd0, 8, "R5 precharge code 3");
    testHold();
    testSaturate();
    testDisable();
    testSleep();
    testSelfMode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule